// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit connects a 32-bit register datapath to a word-wide data memory for byte, halfword and word accesses. For each request it forms the effective byte address by adding a sign-extended 16-bit displacement to a base value. On a store it places the register value on the correct byte lanes of the memory word and produces a 4-bit write-enable mask. On a load it takes the word the memory returns in the same cycle, extracts the addressed byte or halfword, extends it with zeros or copies of its sign bit, and registers the result.

Lanes are big-endian: byte offset 0 within a word is bits [31:24], and offset 3 is bits [7:0]. Write-enable bit j covers memory bits [8j+7:8j], so offset k drives enable bit 3-k. An access whose address is not a multiple of its size is flagged in the cycle of the request, and it neither writes memory nor delivers load data.

Size codes on `req_size` are 00 byte, 01 halfword, 10 word. Code 11 is reserved and always faults.

Top module: `lsu_lane_align`

## Requirements
- R1: `mem_addr` equals `base_addr` plus `addr_offset` sign-extended to 32 bits, modulo 2^32, in the cycle the inputs are presented.
- R2: An aligned byte store at offset k drives exactly enable bit 3-k and places `store_value[7:0]` on all four lanes of `mem_wdata`.
- R3: An aligned halfword store drives enable mask 1100 at offset 0 and 0011 at offset 2, and puts `store_value[15:0]` on both halves of `mem_wdata`.
- R4: An aligned word store drives enable mask 1111 with `mem_wdata` equal to `store_value`.
- R5: `align_fault` is high in a cycle exactly when `req_valid` is high and the access is misaligned. A word is misaligned unless address bits [1:0] are 00. A halfword is misaligned when address bit 0 is 1. A byte is never misaligned. Size code 11 always faults.
- R6: During a faulting access `mem_we` is 0000. After a faulting load, `load_valid` is low in the next cycle and `load_value` keeps its previous value.
- R7: A byte load at offset k returns memory bits [31-8k:24-8k]. It is sign-extended when `req_unsigned` is 0 and zero-extended when it is 1.
- R8: A halfword load returns bits [31:16] at offset 0 and bits [15:0] at offset 2. It is sign-extended or zero-extended under `req_unsigned` in the same way as a byte load.
- R9: A word load returns `mem_rdata` unchanged, whatever the value of `req_unsigned`.
- R10: Results are registered. `load_valid` is high in the cycle after an aligned load, and `load_value` is updated at that point. Reset clears `load_valid` and `load_value`. A load or an idle cycle never asserts `mem_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_unsigned | input | 1 | Zero-extend loaded data when 1 |
| base_addr | input | 32 | Base register value |
| addr_offset | input | 16 | Signed displacement |
| store_value | input | 32 | Register value to store |
| mem_rdata | input | 32 | Word read from memory at `mem_addr` in the same cycle |
| mem_addr | output | 32 | Effective byte address |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_we | output | 4 | Per-byte write enables, bit j covers bits [8j+7:8j] |
| align_fault | output | 1 | Misaligned access flag for this cycle |
| load_valid | output | 1 | Registered load result is valid |
| load_value | output | 32 | Registered, extended load result |

## Verification
Two things can happen in the same cycle. The registered result of a load can appear while the next request is driving its store strobes. Separately, the alignment check can fire in the same cycle that the lane mask would otherwise enable writes. The bench provokes the first case by issuing loads and stores back to back to the same word, including a store followed at once by a load of one of the bytes it wrote. It provokes the second with stores and loads at every misaligned offset, and with the reserved size code, placed between good loads. A behavioural model keeps a byte-addressed copy of memory and predicts the address, strobes, lane data and fault on every clock, plus the registered load result one clock later. Suppressed writes are then exposed by reading the same bytes back.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

  localparam int LANE_W = 8;
  localparam int LANES  = 4;
  localparam int WORD_W = LANE_W * LANES;
  localparam int HALF_W = 2 * LANE_W;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  // True when the low address bits do not fit the access size.
  function automatic logic misaligned(input logic [1:0] sz, input logic [1:0] lo);
    case (sz)
      SZ_BYTE: return 1'b0;
      SZ_HALF: return lo[0];
      SZ_WORD: return |lo;
      default: return 1'b1;
    endcase
  endfunction

  // Big-endian lane mask: byte offset 0 is the top lane.
  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] sz, input logic [1:0] lo);
    logic [LANES-1:0] top;
    top = {1'b1, {(LANES-1){1'b0}}};
    case (sz)
      SZ_BYTE: return top >> lo;
      SZ_HALF: return lo[1] ? 4'b0011 : 4'b1100;
      SZ_WORD: return {LANES{1'b1}};
      default: return '0;
    endcase
  endfunction

  // Widen a right-justified byte or halfword to a full word.
  function automatic logic [WORD_W-1:0] extend_lane(input logic [WORD_W-1:0] v,
                                                    input logic [1:0] sz,
                                                    input logic uns);
    case (sz)
      SZ_BYTE: return {{(WORD_W-LANE_W){~uns & v[LANE_W-1]}}, v[LANE_W-1:0]};
      SZ_HALF: return {{(WORD_W-HALF_W){~uns & v[HALF_W-1]}}, v[HALF_W-1:0]};
      default: return v;
    endcase
  endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFFS_W-1:0] offset,
  output logic [ADDR_W-1:0] ea
);
  localparam int EXT_W = ADDR_W - OFFS_W;

  logic [ADDR_W-1:0] offset_wide;

  assign offset_wide = {{EXT_W{offset[OFFS_W-1]}}, offset};
  assign ea          = base + offset_wide;
endmodule

// File: rtl/lsu_align_check.sv
module lsu_align_check
  import lsu_lane_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] size,
  input  logic [1:0] lo,
  output logic       fault
);
  logic size_bad;

  assign size_bad = misaligned(size, lo);
  assign fault    = req_valid & size_bad;

  // R5: no flag outside a request
  assert_idle_no_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !fault);
  // R5: byte accesses are always legal
  assert_byte_never_faults_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && size == SZ_BYTE) |-> !fault);
  // R5: reserved size always faults
  assert_rsvd_faults_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && size == SZ_RSVD) |-> fault);
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_lane_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              store_en,
  input  logic              fault,
  input  logic [1:0]        size,
  input  logic [1:0]        lo,
  input  logic [WORD_W-1:0] data,
  output logic [WORD_W-1:0] wdata,
  output logic [LANES-1:0]  we
);
  logic [LANES-1:0] mask_raw;
  logic             write_ok;

  assign mask_raw = lane_mask(size, lo);
  assign write_ok = store_en & ~fault;
  assign we       = write_ok ? mask_raw : '0;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam bit ODD = (j % 2) == 1;
    logic [LANE_W-1:0] half_src;
    assign half_src = ODD ? data[HALF_W-1:LANE_W] : data[LANE_W-1:0];
    assign wdata[j*LANE_W +: LANE_W] =
      (size == SZ_BYTE) ? data[LANE_W-1:0] :
      (size == SZ_HALF) ? half_src :
                          data[j*LANE_W +: LANE_W];
  end

  // R6: a faulting access writes nothing
  assert_fault_no_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (we == '0));
  // R10: loads and idle cycles never write
  assert_load_no_we_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !store_en |-> (we == '0));
  // R2: a byte store enables exactly one lane
  assert_byte_one_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (store_en && size == SZ_BYTE) |-> ($countones(we) == 1));
  // R3: a legal halfword store enables one aligned pair
  assert_half_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (store_en && !fault && size == SZ_HALF) |-> (we == 4'b1100 || we == 4'b0011));
  // R4: a legal word store enables every lane
  assert_word_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (store_en && !fault && size == SZ_WORD) |-> (we == 4'b1111));
endmodule

// File: rtl/lsu_load_lane.sv
module lsu_load_lane
  import lsu_lane_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              fault,
  input  logic [1:0]        size,
  input  logic              uns,
  input  logic [1:0]        lo,
  input  logic [WORD_W-1:0] rdata,
  output logic              load_valid,
  output logic [WORD_W-1:0] load_value
);
  logic [LANE_W-1:0] lane_v [LANES];
  logic [LANE_W-1:0] byte_pick;
  logic [HALF_W-1:0] half_pick;
  logic [WORD_W-1:0] justified;
  logic [WORD_W-1:0] widened;
  logic              load_hit;
  logic [1:0]        q_size;
  logic              q_uns;

  for (genvar j = 0; j < LANES; j++) begin : g_split
    assign lane_v[j] = rdata[j*LANE_W +: LANE_W];
  end

  assign byte_pick = lane_v[2'(LANES-1) - lo];
  assign half_pick = lo[1] ? {lane_v[1], lane_v[0]} : {lane_v[3], lane_v[2]};

  always_comb begin
    case (size)
      SZ_BYTE: justified = {{(WORD_W-LANE_W){1'b0}}, byte_pick};
      SZ_HALF: justified = {{(WORD_W-HALF_W){1'b0}}, half_pick};
      default: justified = rdata;
    endcase
  end

  assign widened  = extend_lane(justified, size, uns);
  assign load_hit = load_en & ~fault;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_valid <= 1'b0;
      load_value <= '0;
      q_size     <= SZ_WORD;
      q_uns      <= 1'b0;
    end else begin
      load_valid <= load_hit;
      if (load_hit) begin
        load_value <= widened;
        q_size     <= size;
        q_uns      <= uns;
      end
    end
  end

  // R10: a legal load yields a result one cycle later
  assert_valid_after_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load_hit |=> load_valid);
  // R6: a faulting load leaves the result untouched
  assert_fault_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && fault) |=> (!load_valid && $stable(load_value)));
  // R7: signed byte result carries its sign in the upper bits
  assert_sign_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && q_size == SZ_BYTE && !q_uns) |->
      (load_value[WORD_W-1:LANE_W] == {(WORD_W-LANE_W){load_value[LANE_W-1]}}));
  // R8: unsigned halfword result has a zero upper half
  assert_zero_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && q_size == SZ_HALF && q_uns) |->
      (load_value[WORD_W-1:HALF_W] == '0));
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsu_lane_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_unsigned,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [OFFS_W-1:0] addr_offset,
  input  logic [WORD_W-1:0] store_value,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [LANES-1:0]  mem_we,
  output logic              align_fault,
  output logic              load_valid,
  output logic [WORD_W-1:0] load_value
);
  logic [ADDR_W-1:0] eff_addr;
  logic [1:0]        lane_lo;
  logic              store_req;
  logic              load_req;

  assign lane_lo   = eff_addr[1:0];
  assign store_req = req_valid & req_store;
  assign load_req  = req_valid & ~req_store;
  assign mem_addr  = eff_addr;

  lsu_agen #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_agen (
    .base   (base_addr),
    .offset (addr_offset),
    .ea     (eff_addr)
  );

  lsu_align_check u_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .size      (req_size),
    .lo        (lane_lo),
    .fault     (align_fault)
  );

  lsu_store_lane u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .store_en (store_req),
    .fault    (align_fault),
    .size     (req_size),
    .lo       (lane_lo),
    .data     (store_value),
    .wdata    (mem_wdata),
    .we       (mem_we)
  );

  lsu_load_lane u_load (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (load_req),
    .fault      (align_fault),
    .size       (req_size),
    .uns        (req_unsigned),
    .lo         (lane_lo),
    .rdata      (mem_rdata),
    .load_valid (load_valid),
    .load_value (load_value)
  );
endmodule

// File: tb/lsu_lane_align_test.sv
`timescale 1ns/1ps
module lsu_lane_align_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_unsigned = 1'b0;
  logic [1:0]  req_size = 2'b10;
  logic [31:0] base_addr = '0, store_value = '0;
  logic [15:0] addr_offset = '0;
  logic [31:0] mem_rdata, mem_addr, mem_wdata, load_value;
  logic [3:0]  mem_we;
  logic        align_fault, load_valid;

  int vectors = 0;
  int miscompares = 0;

  logic [7:0]  sm [64];
  logic [31:0] ram [16];
  logic        exp_lv = 1'b0;
  logic [31:0] exp_ld = '0;
  logic [31:0] lfsr = 32'h1bad_5eed;

  always #2.5 clk = ~clk;

  lsu_lane_align uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .base_addr(base_addr),
    .addr_offset(addr_offset), .store_value(store_value), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .align_fault(align_fault), .load_valid(load_valid), .load_value(load_value)
  );

  assign mem_rdata = ram[mem_addr[5:2]];

  always @(posedge clk) begin
    for (int j = 0; j < 4; j++)
      if (mem_we[j]) ram[mem_addr[5:2]][j*8 +: 8] <= mem_wdata[j*8 +: 8];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic st, input logic [1:0] sz,
                       input logic uns, input logic [31:0] b, input logic [15:0] o,
                       input logic [31:0] d);
    longint      sum;
    logic [31:0] ea, ewd, val;
    logic [3:0]  ewe;
    logic        ef;
    int          n, a;
    @(negedge clk);
    req_valid = v; req_store = st; req_size = sz; req_unsigned = uns;
    base_addr = b; addr_offset = o; store_value = d;
    #1;
    sum = longint'(b) + ((o >= 16'h8000) ? longint'(o) - 65536 : longint'(o));
    ea  = sum[31:0];
    n   = 1 << sz;
    a   = int'(ea[5:0]);
    ef  = v && (sz == 2'b11 || (a % n) != 0);
    chk("R1 effective address", mem_addr, ea);
    chk("R5 fault flag", {31'b0, align_fault}, {31'b0, ef});
    ewe = '0;
    if (v && st && !ef)
      for (int i = 0; i < n; i++) ewe[3 - ((a + i) % 4)] = 1'b1;
    chk(ef ? "R6 strobes on fault" : (!(v && st) ? "R10 no strobes" :
        (sz == 0 ? "R2 byte strobes" : (sz == 1 ? "R3 half strobes" : "R4 word strobes"))),
        {28'b0, mem_we}, {28'b0, ewe});
    if (v && st && !ef) begin
      for (int x = 0; x < 4; x++)
        ewd[31 - 8*x -: 8] = 8'(d >> (8 * ((n - 1) - (x % n))));
      chk(sz == 0 ? "R2 byte lanes" : (sz == 1 ? "R3 half lanes" : "R4 word lanes"),
          mem_wdata, ewd);
      for (int i = 0; i < n; i++) sm[(a + i) & 63] = 8'(d >> (8 * (n - 1 - i)));
    end
    if (v && !st && !ef) begin
      val = '0;
      for (int i = 0; i < n; i++) val = (val << 8) | 32'(sm[(a + i) & 63]);
      if (!uns && n < 4 && val[8*n - 1]) val = val | ~((32'h1 << (8*n)) - 1);
      exp_lv = 1'b1;
      exp_ld = val;
    end else begin
      exp_lv = 1'b0;
    end
    @(posedge clk);
    #1;
    chk("R10 load valid", {31'b0, load_valid}, {31'b0, exp_lv});
    chk((v && !st && ef) ? "R6 held result" :
        (sz == 0 ? "R7 byte load" : (sz == 1 ? "R8 half load" : "R9 word load")),
        load_value, exp_ld);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int x = 0; x < 64; x++) sm[x] = 8'(x * 29 + 7);
    for (int w = 0; w < 16; w++) ram[w] = {sm[4*w], sm[4*w+1], sm[4*w+2], sm[4*w+3]};
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset valid", {31'b0, load_valid}, 32'h0);
    chk("R10 reset value", load_value, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    // R4/R9 word stores and loads
    apply(1, 1, 2'b10, 0, 32'h10, 16'h0000, 32'h8123_45F6);
    apply(1, 0, 2'b10, 0, 32'h10, 16'h0000, 32'h0);
    apply(1, 0, 2'b10, 1, 32'h18, 16'hFFFC, 32'h0);
    // R2/R7 byte stores then signed and unsigned loads at every offset
    for (int k = 0; k < 4; k++) apply(1, 1, 2'b00, 0, 32'h20, 16'(k), 32'hABCD_EF80 + 32'(k));
    for (int k = 0; k < 4; k++) begin
      apply(1, 0, 2'b00, 0, 32'h20, 16'(k), 32'h0);
      apply(1, 0, 2'b00, 1, 32'h20, 16'(k), 32'h0);
    end
    // R3/R8 halfword stores and loads
    apply(1, 1, 2'b01, 0, 32'h30, 16'h0000, 32'h1234_9A7E);
    apply(1, 1, 2'b01, 0, 32'h30, 16'h0002, 32'hFFFF_4321);
    for (int k = 0; k < 4; k += 2) begin
      apply(1, 0, 2'b01, 0, 32'h30, 16'(k), 32'h0);
      apply(1, 0, 2'b01, 1, 32'h30, 16'(k), 32'h0);
    end
    // R1 wraparound and negative displacement
    apply(1, 0, 2'b10, 0, 32'hFFFF_FFF0, 16'h0014, 32'h0);
    apply(1, 0, 2'b10, 0, 32'h40, 16'hFFF8, 32'h0);
    apply(0, 1, 2'b10, 0, 32'h8000_0000, 16'h7FFF, 32'h5555_AAAA);
    // R5/R6 misaligned stores and loads after a good load
    apply(1, 0, 2'b10, 0, 32'h10, 16'h0000, 32'h0);
    for (int k = 1; k < 4; k++) begin
      apply(1, 1, 2'b10, 0, 32'h10, 16'(k), 32'hDEAD_BEEF);
      apply(1, 0, 2'b10, 0, 32'h10, 16'(k), 32'h0);
    end
    apply(1, 1, 2'b01, 0, 32'h10, 16'h0001, 32'hDEAD_BEEF);
    apply(1, 0, 2'b01, 1, 32'h10, 16'h0003, 32'h0);
    apply(1, 1, 2'b11, 0, 32'h10, 16'h0000, 32'hDEAD_BEEF);
    apply(1, 0, 2'b11, 0, 32'h10, 16'h0000, 32'h0);
    apply(1, 0, 2'b10, 0, 32'h10, 16'h0000, 32'h0);
    // back-to-back store then load of the same byte
    apply(1, 1, 2'b00, 0, 32'h2C, 16'h0002, 32'h0000_00C3);
    apply(1, 0, 2'b00, 0, 32'h2C, 16'h0002, 32'h0);
    // mixed patterns
    for (int it = 0; it < 600; it++) begin
      logic [31:0] d;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      d = lfsr ^ 32'h9E37_79B9 * 32'(it);
      apply(lfsr[15:14] != 2'b00, lfsr[12], lfsr[11:10], lfsr[13],
            {26'b0, lfsr[5:0]}, {{12{lfsr[9]}}, lfsr[9:6]}, d);
    end
    @(negedge clk);
    req_valid = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule